// File: doc/BRIEF.md
# CAN Overload Frame Sequencer

This block sits beside a CAN protocol engine and handles overload frames in the gap between frames. At every bit-time strobe it looks at the bus level the engine sampled and at where the engine is in the frame. It decides whether an overload frame is due. If one is, it drives the overload flag and then the overload delimiter onto the transmit line. When the delimiter is complete it hands control back to the engine with a one-clock done pulse.

An overload frame has three causes, and each one starts at a different time. An internal "not ready" request is held pending until the next frame boundary, so that the flag falls exactly on the first intermission bit. A dominant level in the first or second intermission bit starts the flag one bit after that bit was sampled. A dominant level in the last bit of an error or overload delimiter does the same, and it also raises a flag that stops the engine from incrementing its error counters for this frame. After its six flag bits the block waits for the bus to go recessive again, because flags from other nodes may overlap its own. It then counts out the delimiter.

Each strobe stands for one bit slot. The phase, bit index and receive bit given with a strobe describe the slot that has just been sampled. A transmit value registered at that strobe is driven during the next slot.

Top module: `can_ovld_seq`

## Requirements
- R1: While reset is asserted and after it is released, `tx_bit` is 1, and `ovld_active`, `ovld_done` and `ecnt_inhibit` are 0.
- R2: When idle, a strobe with `phase`=3 (intermission), `bit_idx` 1 or 2 and `rx_bit`=0 starts an overload flag in the next slot, with `ecnt_inhibit`=0. A dominant level at intermission bit 3 or later starts nothing.
- R3: When idle, a strobe with `phase`=1 (error delimiter) or `phase`=2 (overload delimiter), `bit_idx`=8 and `rx_bit`=0 starts an overload flag in the next slot. `ecnt_inhibit` is 1 for the whole frame this starts. The same level at delimiter bit 7 starts nothing.
- R4: The overload flag is exactly six consecutive slots with `tx_bit`=0. `ovld_active` is 1 from the strobe that starts the frame.
- R5: After the flag, `tx_bit` is 1 and `ovld_active` stays 1 for as long as the sampled bus stays dominant.
- R6: The first recessive slot after the flag counts as delimiter bit 1. When the eighth delimiter bit is sampled recessive, `ovld_done` pulses for exactly one clock, and `ovld_active` and `ecnt_inhibit` fall unless R8 restarts the sequencer.
- R7: If the eighth bit of the block's own delimiter is sampled dominant, a new flag starts in the next slot with `ecnt_inhibit`=1, and no done pulse is given.
- R8: A one-clock `not_ready` pulse is remembered. It starts a flag only in the slot after a strobe with `phase`=0 (end of frame) and `bit_idx`=7, or after a recessive delimiter bit 8: an external one, or the block's own (which also pulses done). The flag then occupies intermission bit 1. Starting any frame clears the remembered request.
- R9: `tx_bit` and `ovld_active` change only at clock edges where `bit_stb` is 1, and `tx_bit` is 1 whenever `ovld_active` is 0.
- R10: While a frame is in progress, `phase` and `bit_idx` have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_stb | input | 1 | One-clock pulse per bit slot |
| rx_bit | input | 1 | Bus level sampled for the current slot (0 = dominant) |
| phase | input | 2 | Field of the sampled slot: 0 end of frame, 1 error delimiter, 2 overload delimiter, 3 intermission |
| bit_idx | input | IDX_W | One-based bit position within that field |
| not_ready | input | 1 | Internal request for extra delay before the next frame |
| tx_bit | output | 1 | Transmit level for the next slot (0 = dominant) |
| ovld_active | output | 1 | An overload frame is in progress |
| ovld_done | output | 1 | One-clock pulse when a delimiter completes |
| ecnt_inhibit | output | 1 | The current frame came from a delimiter-bit-8 trigger; error counters must hold |

## Verification
The bench builds the block with its default lengths: a six-bit flag, an eight-bit delimiter and a seven-bit end-of-frame field. These are the field lengths the bus defines, so every trigger position and boundary (intermission bits 1 to 3, delimiter bits 7 and 8, end-of-frame bit 7) appears at its true index. With these short counts a whole frame takes only about fifteen slots. Random phase sequences, occasional dominant bits and scattered not-ready pulses can therefore chain many frames, including re-arms and long overlapping flags from other nodes, within a short run.

// File: rtl/can_ovld_pkg.sv
package can_ovld_pkg;

  // Field of the interframe region that the sampled slot belongs to
  typedef enum logic [1:0] {
    PH_EOF    = 2'd0,
    PH_ERRDLM = 2'd1,
    PH_OVLDLM = 2'd2,
    PH_INTER  = 2'd3
  } phase_e;

  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FLAG = 2'd1,
    ST_WAIT = 2'd2,
    ST_DLM  = 2'd3
  } ovld_state_e;

endpackage

// File: rtl/can_ovld_cnt.sv
module can_ovld_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (en) begin
      cnt_d = clr ? '0 : cnt + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/can_ovld_trig.sv
module can_ovld_trig
  import can_ovld_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int EOF_LEN = 7,
  parameter int DLM_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [1:0]       phase,
  input  logic [IDX_W-1:0] idx,
  input  logic             rx,
  input  logic             not_ready,
  input  logic             armed,
  input  logic             consume,
  output logic             fire,
  output logic             fire_inhibit,
  output logic             pend
);

  phase_e ph;
  logic   dlm_last;
  logic   dlm_dom;
  logic   inter_dom;
  logic   gap_next;
  logic   pend_en;
  logic   pend_d;

  always_comb begin
    ph        = phase_e'(phase);
    dlm_last  = ((ph == PH_ERRDLM) || (ph == PH_OVLDLM)) &&
                (idx == IDX_W'(DLM_LEN));
    dlm_dom   = dlm_last && !rx;
    inter_dom = (ph == PH_INTER) && !rx &&
                ((idx == IDX_W'(1)) || (idx == IDX_W'(2)));
    // next slot is the first intermission bit
    gap_next  = ((ph == PH_EOF) && (idx == IDX_W'(EOF_LEN))) ||
                (dlm_last && rx);
    fire         = stb && armed && (dlm_dom || inter_dom || (pend && gap_next));
    fire_inhibit = dlm_dom;
  end

  always_comb begin
    pend_en = not_ready || consume;
    pend_d  = (pend && !consume) || not_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (pend_en) begin
      pend <= pend_d;
    end
  end

endmodule

// File: rtl/can_ovld_seq.sv
module can_ovld_seq
  import can_ovld_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int FLAG_LEN = 6,
  parameter int DLM_LEN  = 8,
  parameter int EOF_LEN  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic [1:0]       phase,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             not_ready,
  output logic             tx_bit,
  output logic             ovld_active,
  output logic             ovld_done,
  output logic             ecnt_inhibit
);

  localparam int LONGEST = (FLAG_LEN > DLM_LEN) ? FLAG_LEN : DLM_LEN;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  ovld_state_e      st_q, st_d;
  logic             tx_q, tx_d;
  logic             inh_q, inh_d;
  logic             done_q, done_d;
  logic             cnt_clr, cnt_inc, cnt_en;
  logic [CNT_W-1:0] cnt_q;
  logic             fire, fire_inh, pend, consume;

  can_ovld_trig #(
    .IDX_W  (IDX_W),
    .EOF_LEN(EOF_LEN),
    .DLM_LEN(DLM_LEN)
  ) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (bit_stb),
    .phase       (phase),
    .idx         (bit_idx),
    .rx          (rx_bit),
    .not_ready   (not_ready),
    .armed       (st_q == ST_IDLE),
    .consume     (consume),
    .fire        (fire),
    .fire_inhibit(fire_inh),
    .pend        (pend)
  );

  can_ovld_cnt #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cnt_en),
    .clr  (cnt_clr),
    .cnt  (cnt_q)
  );

  assign cnt_en = cnt_clr || cnt_inc;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    tx_d    = tx_q;
    inh_d   = inh_q;
    done_d  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    consume = 1'b0;
    if (bit_stb) begin
      unique case (st_q)
        ST_IDLE: begin
          if (fire) begin
            st_d    = ST_FLAG;
            tx_d    = 1'b0;
            inh_d   = fire_inh;
            cnt_clr = 1'b1;
            consume = 1'b1;
          end
        end
        ST_FLAG: begin
          if (cnt_q == CNT_W'(FLAG_LEN - 1)) begin
            st_d    = ST_WAIT;
            tx_d    = 1'b1;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_WAIT: begin
          // the first recessive slot is delimiter bit 1
          if (rx_bit) begin
            st_d    = ST_DLM;
            cnt_clr = 1'b1;
          end
        end
        ST_DLM: begin
          if (cnt_q == CNT_W'(DLM_LEN - 2)) begin
            cnt_clr = 1'b1;
            if (!rx_bit) begin
              st_d  = ST_FLAG;
              tx_d  = 1'b0;
              inh_d = 1'b1;
            end else begin
              done_d = 1'b1;
              if (pend) begin
                st_d    = ST_FLAG;
                tx_d    = 1'b0;
                inh_d   = 1'b0;
                consume = 1'b1;
              end else begin
                st_d  = ST_IDLE;
                inh_d = 1'b0;
              end
            end
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tx_q  <= 1'b1;
      inh_q <= 1'b0;
    end else if (bit_stb) begin
      st_q  <= st_d;
      tx_q  <= tx_d;
      inh_q <= inh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign tx_bit       = tx_q;
  assign ovld_active  = (st_q != ST_IDLE);
  assign ovld_done    = done_q;
  assign ecnt_inhibit = inh_q;

endmodule

// File: rtl/can_ovld_chk.sv
module can_ovld_chk #(
  parameter int FLAG_LEN = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic tx_bit,
  input logic ovld_active,
  input logic ovld_done,
  input logic ecnt_inhibit
);

  localparam int RUN_W = $clog2(FLAG_LEN + 2) + 1;

  logic [RUN_W-1:0] low_run;

  // dominant transmit slots seen in a row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (bit_stb) begin
      if (tx_bit) begin
        low_run <= '0;
      end else if (low_run != {RUN_W{1'b1}}) begin
        low_run <= low_run + RUN_W'(1);
      end
    end
  end

  assert_flag_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RUN_W'(FLAG_LEN));

  assert_idle_recessive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ovld_active |-> tx_bit);

  assert_hold_between_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(tx_bit) && $stable(ovld_active)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovld_done |=> !ovld_done);

  assert_done_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovld_done |-> $past(ovld_active));

  assert_inhibit_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_inhibit |-> ovld_active);

endmodule

bind can_ovld_seq can_ovld_chk #(.FLAG_LEN(FLAG_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_stb     (bit_stb),
  .tx_bit      (tx_bit),
  .ovld_active (ovld_active),
  .ovld_done   (ovld_done),
  .ecnt_inhibit(ecnt_inhibit)
);

// File: tb/can_ovld_seq_test.sv
`timescale 1ns/1ps
module can_ovld_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_stb;
  logic       rx_bit;
  logic [1:0] phase;
  logic [3:0] bit_idx;
  logic       not_ready;
  logic       tx_bit, ovld_active, ovld_done, ecnt_inhibit;

  int n_vec = 0;
  int n_bad = 0;

  // reference model state
  int m_st;    // 0 idle, 1 flag, 2 wait, 3 delimiter
  int m_cnt;
  bit m_pend, m_inh, m_done;

  always #2.5 clk = ~clk;

  can_ovld_seq uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .phase(phase), .bit_idx(bit_idx), .not_ready(not_ready),
    .tx_bit(tx_bit), .ovld_active(ovld_active), .ovld_done(ovld_done),
    .ecnt_inhibit(ecnt_inhibit)
  );

  function automatic bit exp_tx();
    return (m_st == 1) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "tx_bit", tx_bit, exp_tx());
    chk(tag, "ovld_active", ovld_active, m_st != 0);
    chk(tag, "ecnt_inhibit", ecnt_inhibit, m_inh);
    chk(tag, "ovld_done", ovld_done, m_done);
  endtask

  task automatic m_start(bit inh);
    m_st = 1; m_cnt = 0; m_inh = inh; m_pend = 1'b0;
  endtask

  task automatic model_step(int ph, int idx, bit rx);
    bit dl;
    m_done = 1'b0;
    case (m_st)
      0: begin
        dl = ((ph == 1) || (ph == 2)) && (idx == 8);
        if (dl && !rx) m_start(1'b1);
        else if (ph == 3 && (idx == 1 || idx == 2) && !rx) m_start(1'b0);
        else if (m_pend && ((ph == 0 && idx == 7) || (dl && rx))) m_start(1'b0);
      end
      1: begin
        m_cnt++;
        if (m_cnt == 6) m_st = 2;
      end
      2: if (rx) begin m_st = 3; m_cnt = 1; end
      default: begin
        m_cnt++;
        if (m_cnt == 8) begin
          if (!rx) begin
            m_st = 1; m_cnt = 0; m_inh = 1'b1;
          end else begin
            m_done = 1'b1;
            if (m_pend) m_start(1'b0);
            else begin m_st = 0; m_inh = 1'b0; end
          end
        end
      end
    endcase
  endtask

  // one bit slot: ext is the level the other nodes drive
  task automatic slot(string tag, int ph, int idx, bit ext);
    @(negedge clk);
    phase   = 2'(ph);
    bit_idx = 4'(idx);
    rx_bit  = exp_tx() & ext;
    bit_stb = 1'b1;
    model_step(ph, idx, rx_bit);
    @(negedge clk);
    bit_stb = 1'b0;
    cmp_all(tag);
    @(negedge clk);
    m_done = 1'b0;
    chk(tag, "done one clock / hold", ovld_done, 1'b0);
    chk(tag, "tx hold between strobes", tx_bit, exp_tx());
  endtask

  task automatic nr_pulse();
    @(negedge clk);
    not_ready = 1'b1;
    m_pend = 1'b1;
    @(negedge clk);
    not_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_st = 0; m_cnt = 0; m_pend = 0; m_inh = 0; m_done = 0;
    @(negedge clk);
    chk("R1", "tx in reset", tx_bit, 1'b1);
    chk("R1", "active in reset", ovld_active, 1'b0);
    chk("R1", "done in reset", ovld_done, 1'b0);
    chk("R1", "inhibit in reset", ecnt_inhibit, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1");
  endtask

  // flag slots, then dom_slots of dominant bus, then the delimiter
  task automatic run_frame(string tag, int dom_slots, bit last_ext);
    for (int i = 0; i < 6; i++) slot("R4", 2, (i % 8) + 1, 1'b1);
    for (int i = 0; i < dom_slots; i++) slot("R5", 3, 1, 1'b0);
    for (int i = 1; i <= 8; i++) slot(tag, 1, 8, (i == 8) ? last_ext : 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_stb = 1'b0; rx_bit = 1'b1; phase = '0;
    bit_idx = '0; not_ready = 1'b0;
    do_reset();

    // R2: intermission bit 1 dominant
    slot("R2", 3, 1, 1'b0);
    run_frame("R6", 0, 1'b1);
    // R2: intermission bit 2 dominant
    slot("R2", 3, 1, 1'b1);
    slot("R2", 3, 2, 1'b0);
    run_frame("R6", 0, 1'b1);
    // R2: bit 3 dominant must not trigger
    slot("R2", 3, 1, 1'b1);
    slot("R2", 3, 2, 1'b1);
    slot("R2", 3, 3, 1'b0);
    slot("R2", 0, 1, 1'b1);

    // R3: error delimiter bit 7 dominant no trigger, bit 8 triggers
    slot("R3", 1, 7, 1'b0);
    slot("R3", 1, 8, 1'b0);
    run_frame("R3", 0, 1'b1);
    // R3: overload delimiter bit 8
    slot("R3", 2, 8, 1'b0);
    // R5: extended dominant from other nodes
    run_frame("R5", 5, 1'b1);

    // R7: own delimiter bit 8 dominant re-arms
    slot("R7", 3, 1, 1'b0);
    run_frame("R7", 0, 1'b0);
    run_frame("R6", 2, 1'b1);

    // R8: request mid-frame, deferred to intermission bit 1
    slot("R8", 0, 1, 1'b1);
    slot("R8", 0, 2, 1'b1);
    nr_pulse();
    for (int i = 3; i <= 7; i++) slot("R8", 0, i, 1'b1);
    run_frame("R8", 0, 1'b1);
    // R8: request then recessive error delimiter bit 8
    nr_pulse();
    slot("R8", 3, 1, 1'b1);
    slot("R8", 1, 8, 1'b1);
    // R8: request during own frame restarts at its end
    nr_pulse();
    run_frame("R8", 1, 1'b1);
    run_frame("R6", 0, 1'b1);

    // R10: phase ignored while a frame is running
    slot("R10", 3, 2, 1'b0);
    for (int i = 0; i < 6; i++) slot("R10", 1, 8, 1'b0);
    for (int i = 0; i < 8; i++) slot("R10", 3, 1, 1'b1);

    // R1: reset mid-frame
    slot("R1", 3, 1, 1'b0);
    slot("R1", 3, 2, 1'b1);
    do_reset();

    // R9: random slots against the model
    void'($urandom(32'h0c4a_5eed));
    for (int n = 0; n < 3000; n++) begin
      int ph, idx;
      bit ext;
      ph  = int'($urandom_range(3, 0));
      idx = int'($urandom_range(8, 1));
      ext = ($urandom_range(99, 0) >= 12);
      if ($urandom_range(99, 0) < 3) nr_pulse();
      slot("R9", ph, idx, ext);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule